// File: doc/BRIEF.md
# PPS-Disciplined Seconds/Ticks Timekeeper

This block keeps wall-clock time as a pair of 32-bit counters: a ticks counter that advances once per clock and a seconds counter that advances whenever ticks wraps at a programmable ticks-per-second value. Software writes a target time (seconds and ticks) through a small settings write port. The new time is then applied either on the next clock or at the next pulse-per-second edge. The edge polarity and the pulse source (external connector or companion-board link) are both selectable.

The pulse input goes through a synchronizer and an edge detector. On every qualifying edge the block also captures the running time, so software can read back the exact time of the last pulse next to the free-running time. Writing the seconds value is what arms a load. Once the load has been applied, the block disarms and waits for the next seconds write.

Top module: `pps_timekeeper`

## Requirements
- R1: While reset is asserted and after it is released, both running counters and both captured values read 0, no load is armed, flags and immediate mode are 0, and ticks-per-second holds the TPS_RESET parameter.
- R2: When no load is applied, ticks advances by 1 each clock. When ticks is at or above ticks-per-second minus 1, ticks returns to 0 and seconds increases by 1 on that same clock.
- R3: A write with select 4 sets ticks-per-second, and later rollovers use the new value.
- R4: A write with select 0 stores the seconds load value and arms a load. A write with select 1 stores the ticks load value. With immediate mode set (select 3, data bit 0 = 1), the outputs show the load values one clock after the arming write, and counting then resumes from them.
- R5: With immediate mode 0, an armed load waits for the next qualifying pulse edge and the counters keep running until then. After the load is applied, the block disarms, so later edges reload nothing.
- R6: Flags are written with select 2. Flags bit 0 selects the qualifying edge: 0 = falling (default), 1 = rising. The other polarity causes neither a load nor a capture.
- R7: Flags bit 1 selects the pulse source: 0 = `pps_ext`, 1 = `pps_link`. The unselected input has no effect.
- R8: A pulse level change that is sampled on clock edge k takes effect (load and capture) on clock edge k+2, because of two synchronizer stages.
- R9: On a qualifying edge, `pps_secs`/`pps_ticks` take the running time of the cycle in which the edge was detected, before any load from that edge. Between edges they hold their value.
- R10: A ticks-value write alone does not arm a load. Writes with selects 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_sel | input | 3 | Settings select (0 secs load, 1 ticks load, 2 flags, 3 immediate, 4 ticks-per-second) |
| cfg_wdata | input | W | Settings write data |
| pps_ext | input | 1 | Pulse from external connector |
| pps_link | input | 1 | Pulse from companion-board link |
| now_secs | output | W | Running seconds |
| now_ticks | output | W | Running ticks |
| pps_secs | output | W | Seconds captured at last qualifying edge |
| pps_ticks | output | W | Ticks captured at last qualifying edge |

## Verification
A settings write takes effect on the edge that samples it, and an immediate load appears one clock after that edge. A pulse level change reaches the counters and the captured time two edges after it is first sampled. The bench drives inputs on falling clock edges and steps a behavioural model on rising edges using those same inputs. It compares all four outputs with the model on every falling edge. Directed checks count negedges after each stimulus to confirm the one-cycle load latency and the two-stage pulse latency.

// File: rtl/tk_pkg.sv
package tk_pkg;

    typedef enum logic [2:0] {
        SEL_LD_SECS  = 3'd0,
        SEL_LD_TICKS = 3'd1,
        SEL_FLAGS    = 3'd2,
        SEL_IMMED    = 3'd3,
        SEL_TPS      = 3'd4
    } tk_sel_e;

    localparam int FLAG_POL_BIT = 0;
    localparam int FLAG_SRC_BIT = 1;

endpackage

// File: rtl/tk_cfg_regs.sv
module tk_cfg_regs
    import tk_pkg::*;
#(
    parameter int          W         = 32,
    parameter int unsigned TPS_RESET = 1000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [2:0]   sel,
    input  logic [W-1:0] wdata,
    input  logic         load_fire,
    output logic [W-1:0] ld_secs,
    output logic [W-1:0] ld_ticks,
    output logic [W-1:0] tps,
    output logic         pol_rise,
    output logic         src_link,
    output logic         immed,
    output logic         armed
);

    typedef struct packed {
        logic [W-1:0] ld_secs;
        logic [W-1:0] ld_ticks;
        logic [W-1:0] tps;
        logic         pol_rise;
        logic         src_link;
        logic         immed;
        logic         armed;
    } cfg_t;

    localparam cfg_t CFG_RST = '{ld_secs: '0, ld_ticks: '0, tps: W'(TPS_RESET),
                                 pol_rise: 1'b0, src_link: 1'b0, immed: 1'b0,
                                 armed: 1'b0};

    cfg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_fire) s_d.armed = 1'b0;
        if (we) begin
            case (sel)
                SEL_LD_SECS: begin
                    s_d.ld_secs = wdata;
                    s_d.armed   = 1'b1;
                end
                SEL_LD_TICKS: s_d.ld_ticks = wdata;
                SEL_FLAGS: begin
                    s_d.pol_rise = wdata[FLAG_POL_BIT];
                    s_d.src_link = wdata[FLAG_SRC_BIT];
                end
                SEL_IMMED: s_d.immed = wdata[0];
                SEL_TPS:   s_d.tps   = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= CFG_RST;
        else        s_q <= s_d;
    end

    assign ld_secs  = s_q.ld_secs;
    assign ld_ticks = s_q.ld_ticks;
    assign tps      = s_q.tps;
    assign pol_rise = s_q.pol_rise;
    assign src_link = s_q.src_link;
    assign immed    = s_q.immed;
    assign armed    = s_q.armed;

endmodule

// File: rtl/tk_pps_detect.sv
module tk_pps_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pps_ext,
    input  logic pps_link,
    input  logic src_link,
    input  logic pol_rise,
    output logic evt
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES:0] shift;
    } det_t;

    det_t s_d, s_q;
    logic raw;
    logic cur_lvl, prev_lvl;

    always_comb begin
        raw       = src_link ? pps_link : pps_ext;
        s_d.shift = {s_q.shift[LAST:0], raw};
        cur_lvl   = s_q.shift[LAST];
        prev_lvl  = s_q.shift[SYNC_STAGES];
        evt       = pol_rise ? (cur_lvl & ~prev_lvl) : (~cur_lvl & prev_lvl);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/tk_counter.sv
module tk_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] tps,
    input  logic         load_fire,
    input  logic [W-1:0] ld_secs,
    input  logic [W-1:0] ld_ticks,
    input  logic         pps_evt,
    output logic [W-1:0] now_secs,
    output logic [W-1:0] now_ticks,
    output logic [W-1:0] cap_secs,
    output logic [W-1:0] cap_ticks
);

    typedef struct packed {
        logic [W-1:0] now_secs;
        logic [W-1:0] now_ticks;
        logic [W-1:0] cap_secs;
        logic [W-1:0] cap_ticks;
    } cnt_t;

    cnt_t s_d, s_q;
    logic wrap;

    always_comb begin
        s_d  = s_q;
        wrap = (s_q.now_ticks >= (tps - W'(1)));
        if (pps_evt) begin
            s_d.cap_secs  = s_q.now_secs;
            s_d.cap_ticks = s_q.now_ticks;
        end
        if (load_fire) begin
            s_d.now_secs  = ld_secs;
            s_d.now_ticks = ld_ticks;
        end else if (wrap) begin
            s_d.now_ticks = '0;
            s_d.now_secs  = s_q.now_secs + W'(1);
        end else begin
            s_d.now_ticks = s_q.now_ticks + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign now_secs  = s_q.now_secs;
    assign now_ticks = s_q.now_ticks;
    assign cap_secs  = s_q.cap_secs;
    assign cap_ticks = s_q.cap_ticks;

endmodule

// File: rtl/pps_timekeeper.sv
module pps_timekeeper #(
    parameter int          W           = 32,
    parameter int unsigned TPS_RESET   = 1000,
    parameter int          SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_we,
    input  logic [2:0]   cfg_sel,
    input  logic [W-1:0] cfg_wdata,
    input  logic         pps_ext,
    input  logic         pps_link,
    output logic [W-1:0] now_secs,
    output logic [W-1:0] now_ticks,
    output logic [W-1:0] pps_secs,
    output logic [W-1:0] pps_ticks
);

    logic [W-1:0] ld_secs_w, ld_ticks_w, tps_w;
    logic         pol_rise_w, src_link_w, immed_w, armed_w;
    logic         pps_evt, load_fire;

    assign load_fire = armed_w & (immed_w | pps_evt);

    tk_cfg_regs #(.W(W), .TPS_RESET(TPS_RESET)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .load_fire(load_fire), .ld_secs(ld_secs_w), .ld_ticks(ld_ticks_w),
        .tps(tps_w), .pol_rise(pol_rise_w), .src_link(src_link_w),
        .immed(immed_w), .armed(armed_w)
    );

    tk_pps_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk(clk), .rst_n(rst_n), .pps_ext(pps_ext), .pps_link(pps_link),
        .src_link(src_link_w), .pol_rise(pol_rise_w), .evt(pps_evt)
    );

    tk_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tps(tps_w), .load_fire(load_fire),
        .ld_secs(ld_secs_w), .ld_ticks(ld_ticks_w), .pps_evt(pps_evt),
        .now_secs(now_secs), .now_ticks(now_ticks),
        .cap_secs(pps_secs), .cap_ticks(pps_ticks)
    );

endmodule

// File: rtl/tk_timekeeper_chk.sv
module tk_timekeeper_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cfg_we,
    input logic [2:0]   cfg_sel,
    input logic         load_fire,
    input logic         pps_evt,
    input logic [W-1:0] tps,
    input logic [W-1:0] ld_secs,
    input logic [W-1:0] ld_ticks,
    input logic [W-1:0] now_secs,
    input logic [W-1:0] now_ticks,
    input logic [W-1:0] pps_secs,
    input logic [W-1:0] pps_ticks
);

    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_fire && (now_ticks < tps - W'(1))) |=>
            (now_ticks == $past(now_ticks) + W'(1)) && $stable(now_secs));

    // R2
    tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_fire && (now_ticks >= tps - W'(1))) |=>
            (now_ticks == '0) && (now_secs == $past(now_secs) + W'(1)));

    // R4
    load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_fire |=> (now_secs == $past(ld_secs)) && (now_ticks == $past(ld_ticks)));

    // R5
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fire && !(cfg_we && cfg_sel == 3'd0)) |=> !load_fire);

    // R9
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pps_evt |=> (pps_secs == $past(now_secs)) && (pps_ticks == $past(now_ticks)));

    // R9
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pps_evt |=> $stable(pps_secs) && $stable(pps_ticks));

endmodule

bind pps_timekeeper tk_timekeeper_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .load_fire(load_fire), .pps_evt(pps_evt), .tps(tps_w),
    .ld_secs(ld_secs_w), .ld_ticks(ld_ticks_w),
    .now_secs(now_secs), .now_ticks(now_ticks),
    .pps_secs(pps_secs), .pps_ticks(pps_ticks)
);

// File: tb/pps_timekeeper_bench.sv
module pps_timekeeper_bench;

    localparam int TPS0 = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = '0;
    logic        pps_ext = 1'b0;
    logic        pps_link = 1'b0;
    logic [31:0] now_secs, now_ticks, pps_secs, pps_ticks;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string phase = "R1";

    always #10 clk = ~clk;

    pps_timekeeper #(.W(32), .TPS_RESET(TPS0), .SYNC_STAGES(2)) u_pps_timekeeper (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .pps_ext(pps_ext), .pps_link(pps_link),
        .now_secs(now_secs), .now_ticks(now_ticks),
        .pps_secs(pps_secs), .pps_ticks(pps_ticks)
    );

    // reference model state
    longint m_secs, m_ticks, m_csecs, m_cticks, m_lds, m_ldt, m_tps;
    bit     m_pol, m_src, m_imm, m_arm;
    bit     m_hist[$];

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_secs = 0; m_ticks = 0; m_csecs = 0; m_cticks = 0;
            m_lds = 0; m_ldt = 0; m_tps = TPS0;
            m_pol = 0; m_src = 0; m_imm = 0; m_arm = 0;
            m_hist = '{1'b0, 1'b0, 1'b0};
        end else begin
            bit seen, fire;
            seen = m_pol ? (m_hist[1] && !m_hist[2]) : (!m_hist[1] && m_hist[2]);
            fire = m_arm && (m_imm || seen);
            if (seen) begin
                m_csecs = m_secs; m_cticks = m_ticks;
            end
            if (fire) begin
                m_secs = m_lds; m_ticks = m_ldt;
            end else if (m_ticks >= ((m_tps - 1) & 64'hFFFF_FFFF)) begin
                m_ticks = 0; m_secs = (m_secs + 1) & 64'hFFFF_FFFF;
            end else begin
                m_ticks = m_ticks + 1;
            end
            m_hist.push_front(m_src ? pps_link : pps_ext);
            void'(m_hist.pop_back());
            if (fire) m_arm = 0;
            if (cfg_we) begin
                case (cfg_sel)
                    3'd0: begin m_lds = cfg_wdata; m_arm = 1; end
                    3'd1: m_ldt = cfg_wdata;
                    3'd2: begin m_pol = cfg_wdata[0]; m_src = cfg_wdata[1]; end
                    3'd3: m_imm = cfg_wdata[0];
                    3'd4: m_tps = cfg_wdata;
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            chk({phase, " now_secs"},  now_secs,  m_secs);
            chk({phase, " now_ticks"}, now_ticks, m_ticks);
            chk({phase, " pps_secs"},  pps_secs,  m_csecs);
            chk({phase, " pps_ticks"}, pps_ticks, m_cticks);
        end
    end

    task automatic wr(input logic [2:0] s, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        longint seen_s, seen_t;
        phase = "R1";
        idle(5);
        chk("R1 reset secs", now_secs, 0);
        chk("R1 reset ticks", now_ticks, 0);
        rst_n = 1'b1;
        idle(2);
        phase = "R2";
        idle(25);
        chk("R2 secs after wraps", now_secs >= 2, 1);

        phase = "R3";
        wr(3'd4, 32'd5);
        idle(12);

        phase = "R4";
        wr(3'd1, 32'd3);
        wr(3'd3, 32'd1);
        wr(3'd0, 32'd100);
        @(negedge clk);
        chk("R4 imm load secs", now_secs, 100);
        chk("R4 imm load ticks", now_ticks, 3);
        idle(4);

        phase = "R10";
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd6, 32'h0000_0003);
        wr(3'd7, 32'h0000_0001);
        wr(3'd1, 32'd0);
        idle(6);
        chk("R10 no reload to ticks 0 value", now_secs > 100, 1);

        phase = "R5";
        wr(3'd3, 32'd0);
        wr(3'd1, 32'd1);
        wr(3'd0, 32'd500);
        idle(10);
        chk("R5 no load without edge", now_secs == 500, 0);
        pps_ext = 1'b1;
        idle(6);
        chk("R6 rising ignored under falling", now_secs == 500, 0);

        phase = "R8";
        @(negedge clk);
        pps_ext = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R8 not yet at k+1", now_secs == 500, 0);
        seen_s = now_secs; seen_t = now_ticks;
        @(negedge clk);
        chk("R8 load at k+2 secs", now_secs, 500);
        chk("R8 load at k+2 ticks", now_ticks, 1);
        chk("R9 captured secs", pps_secs, seen_s);
        chk("R9 captured ticks", pps_ticks, seen_t);

        phase = "R5";
        idle(3);
        pps_ext = 1'b1;
        idle(4);
        pps_ext = 1'b0;
        idle(20);
        chk("R5 disarmed after load", now_secs >= 503, 1);

        phase = "R6";
        wr(3'd2, 32'd1);
        wr(3'd1, 32'd2);
        wr(3'd0, 32'd700);
        idle(3);
        pps_ext = 1'b1;
        idle(3);
        chk("R6 rising load secs", now_secs, 700);
        chk("R6 rising load ticks", now_ticks, 2);
        idle(3);
        pps_ext = 1'b0;
        idle(4);

        phase = "R7";
        wr(3'd2, 32'd3);
        wr(3'd0, 32'd900);
        idle(2);
        pps_ext = 1'b1;
        idle(4);
        pps_ext = 1'b0;
        idle(4);
        chk("R7 unselected source ignored", now_secs == 900, 0);
        pps_link = 1'b1;
        idle(3);
        chk("R7 link source load", now_secs, 900);
        idle(5);
        pps_link = 1'b0;
        idle(5);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule